// File: doc/BRIEF.md
# Key-Locked Cell Control Register Block

This block holds the control and configuration words of a configurable logic cell and presents them to a 32-bit register bus that qualifies every write with four byte-lane strobes. It owns the cell's global enable, a stop bit, and an indirect configuration port. The stop bit decides whether a debug halt freezes the cell. The indirect port consists of a 6-bit address, a 32-bit data word and a load strobe that fires once per request. Six further configuration words are stored here and read back over the bus: the input edge-filter and synchronizer selection, the input source selection, and two pairs of mux-select words.

A set-once lock protects the enable bit and the six configuration words. The lock is set by one full-width write that carries a 16-bit key and is made while the privileged-write gate is open. After that, those words keep their values until system reset. The load-request bit, the stop bit, and the indirect address and data words stay writable, so configuration can still be streamed into the cell while it is locked. When the global enable is low, the cell forces its outputs low and resets its state machines. Its counters and controller are only held, so they can be preloaded. The enable output drives all of this.

Top module: `cell_ctrl_regs`

## Requirements
- R1: After reset every output is 0 and every register reads 0.
- R2: A write to the control word (index 0) with byte lane 0 enabled and bit 0 set makes `loadStrobe` high for exactly the one cycle after the write edge. Bit 0 always reads back as 0.
- R3: The indirect address (index 1, 6 bits) and data (index 2, 32 bits) words can be read and written. They drive `loadAddr` and `loadData` directly.
- R4: A write changes only the bytes whose `wrStrb` bit is set. A write with no strobe bit set changes nothing.
- R5: The lock (index 9, bit 0) is set only by a write that meets all of these: `privEn` is 1, `wrStrb` is 4'hF, bits 31:16 equal 16'h5A5A, and bit 0 is 1. Every other write leaves it clear, and so does a key delivered as two half-word writes.
- R6: Once set, the lock stays 1 until reset, even after further writes to its word.
- R7: While locked, writes to the six configuration words (indices 3 to 8) and to the enable bit (control bit 1) have no effect. The control word's stop bit (bit 2) and load bit stay active, and so do the indirect address and data words.
- R8: When unlocked, the configuration words can be read and written with these field widths: filter 24 bits, source select 8, each local-select word 20, each global-select word 28. Bits above these widths read 0.
- R9: `freeze` equals the stop bit AND `dbgHalt`, delayed by one register. When the stop bit is 0, a halt is ignored.
- R10: `rdData` shows the addressed word one cycle after `rdEn`. Unmapped indices and the key field (lock word bits 31:16) read as 0.
- R11: `globalEn` follows control bit 1 from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| wrEn | input | 1 | Write request |
| wrAddr | input | 4 | Word index of the write |
| wrData | input | 32 | Write data |
| wrStrb | input | 4 | Byte-lane write strobes |
| privEn | input | 1 | Privileged-write gate, needed to set the lock |
| rdEn | input | 1 | Read request |
| rdAddr | input | 4 | Word index of the read |
| rdData | output | 32 | Read data, one cycle after `rdEn` |
| dbgHalt | input | 1 | CPU debug halt indication |
| globalEn | output | 1 | Cell global enable and soft reset (active high) |
| freeze | output | 1 | Freeze request for the cell's sequential elements |
| loadStrobe | output | 1 | One-cycle indirect load pulse |
| loadAddr | output | 6 | Indirect load address |
| loadData | output | 32 | Indirect load data |
| lockState | output | 1 | Lock status |

## Verification
The hardest state to reach is a lock that has been set, with its protection then probed alongside the bits that must stay writable. The stimulus first fills every configuration word and the enable bit with known non-zero values. It then sends each near-miss lock write: wrong key, partial lane set, gate closed, bit 0 clear, and a key split into two halves. Only after those does it send the valid key. Once locked, the bench writes zeros over the protected words and pulses load and stop in the same control word. Reading back the unchanged values and watching the enable and strobe pins shows, at the ports, that the lock filtered the write bit by bit.

// File: rtl/cell_ctrl_pkg.sv
package cell_ctrl_pkg;
  // bus word indices
  localparam int REG_AW      = 4;
  localparam logic [REG_AW-1:0] IDX_CTRL   = 4'd0;
  localparam logic [REG_AW-1:0] IDX_LDADDR = 4'd1;
  localparam logic [REG_AW-1:0] IDX_LDDATA = 4'd2;
  localparam logic [REG_AW-1:0] IDX_LOCK   = 4'd9;
  localparam int CFG_BASE    = 3;
  localparam int NUM_CFG     = 6;
  // control word bit positions
  localparam int CTRL_LOAD_BIT = 0;
  localparam int CTRL_EN_BIT   = 1;
  localparam int CTRL_STOP_BIT = 2;
  // lock key
  localparam logic [15:0] LOCK_KEY = 16'h5A5A;

  typedef struct packed {
    logic               ldAddrWr;
    logic               ldDataWr;
    logic               enWr;
    logic               stopWr;
    logic               loadPulse;
    logic               lockSet;
    logic [NUM_CFG-1:0] cfgWr;
  } wrStrobes_t;
endpackage

// File: rtl/cell_ctrl_decode.sv
module cell_ctrl_decode
  import cell_ctrl_pkg::*;
(
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [15:0]       wrKey,
  input  logic              wrBit0,
  input  logic [3:0]        wrStrb,
  input  logic              privEn,
  input  logic              lockState,
  output wrStrobes_t        strobes
);
  logic hitCtrl;
  logic hitLock;

  always_comb begin
    hitCtrl = wrEn && (wrAddr == IDX_CTRL);
    hitLock = wrEn && (wrAddr == IDX_LOCK);
    strobes = '0;
    strobes.ldAddrWr  = wrEn && (wrAddr == IDX_LDADDR);
    strobes.ldDataWr  = wrEn && (wrAddr == IDX_LDDATA);
    strobes.stopWr    = hitCtrl && wrStrb[0];
    strobes.loadPulse = hitCtrl && wrStrb[0] && wrBit0;
    strobes.enWr      = hitCtrl && wrStrb[0] && !lockState;
    strobes.lockSet   = hitLock && privEn && (wrStrb == 4'hF)
                        && (wrKey == LOCK_KEY) && wrBit0;
    for (int g = 0; g < NUM_CFG; g++) begin
      strobes.cfgWr[g] = wrEn && !lockState
                         && (wrAddr == REG_AW'(CFG_BASE + g));
    end
  end
endmodule

// File: rtl/cell_ctrl_store.sv
module cell_ctrl_store
  import cell_ctrl_pkg::*;
#(
  parameter int LD_AW     = 6,
  parameter int NUM_IN    = 8,
  parameter int LCL_SEL_W = 5,
  parameter int GLB_SEL_W = 7
)(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobes_t        strobes,
  input  logic [31:0]       wrData,
  input  logic [3:0]        wrStrb,
  input  logic              rdEn,
  input  logic [REG_AW-1:0] rdAddr,
  input  logic              dbgHalt,
  output logic [31:0]       rdData,
  output logic              globalEn,
  output logic              freeze,
  output logic              loadStrobe,
  output logic [LD_AW-1:0]  loadAddr,
  output logic [31:0]       loadData,
  output logic              lockState
);
  localparam int FILT_W = 3 * NUM_IN;
  localparam int SRC_W  = NUM_IN;
  localparam int LCL_W  = (NUM_IN / 2) * LCL_SEL_W;
  localparam int GLB_W  = (NUM_IN / 2) * GLB_SEL_W;

  function automatic logic [31:0] widthMask(input int w);
    logic [63:0] m;
    m = (64'd1 << w) - 64'd1;
    return m[31:0];
  endfunction

  function automatic int cfgWidth(input int idx);
    case (idx)
      0:       return FILT_W;
      1:       return SRC_W;
      2, 3:    return LCL_W;
      default: return GLB_W;
    endcase
  endfunction

  function automatic logic [31:0] mergeLanes(input logic [31:0] cur,
                                             input logic [31:0] nxt,
                                             input logic [3:0]  lanes,
                                             input logic [31:0] mask);
    logic [31:0] res;
    res = cur;
    for (int b = 0; b < 4; b++) begin
      if (lanes[b]) res[8*b +: 8] = nxt[8*b +: 8];
    end
    return res & mask;
  endfunction

  localparam logic [31:0] LD_MASK = widthMask(LD_AW);

  logic [31:0] cfgReg [NUM_CFG];
  logic        enReg;
  logic        stopReg;
  logic [31:0] ldAddrReg;
  logic [31:0] ldDataReg;
  logic        lockReg;
  logic        pulseReg;
  logic        freezeReg;
  logic [31:0] rdReg;
  logic [31:0] rdValue;

  for (genvar g = 0; g < NUM_CFG; g++) begin : gCfg
    localparam logic [31:0] CFG_MASK = widthMask(cfgWidth(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cfgReg[g] <= '0;
      else if (strobes.cfgWr[g]) cfgReg[g] <= mergeLanes(cfgReg[g], wrData, wrStrb, CFG_MASK);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      stopReg   <= 1'b0;
      ldAddrReg <= '0;
      ldDataReg <= '0;
      lockReg   <= 1'b0;
      pulseReg  <= 1'b0;
      freezeReg <= 1'b0;
      rdReg     <= '0;
    end else begin
      if (strobes.enWr)     enReg   <= wrData[CTRL_EN_BIT];
      if (strobes.stopWr)   stopReg <= wrData[CTRL_STOP_BIT];
      if (strobes.ldAddrWr) ldAddrReg <= mergeLanes(ldAddrReg, wrData, wrStrb, LD_MASK);
      if (strobes.ldDataWr) ldDataReg <= mergeLanes(ldDataReg, wrData, wrStrb, '1);
      if (strobes.lockSet)  lockReg <= 1'b1;
      pulseReg  <= strobes.loadPulse;
      freezeReg <= stopReg && dbgHalt;
      rdReg     <= rdEn ? rdValue : '0;
    end
  end

  always_comb begin
    rdValue = '0;
    case (rdAddr)
      IDX_CTRL: begin
        rdValue[CTRL_EN_BIT]   = enReg;
        rdValue[CTRL_STOP_BIT] = stopReg;
      end
      IDX_LDADDR: rdValue = ldAddrReg;
      IDX_LDDATA: rdValue = ldDataReg;
      IDX_LOCK:   rdValue[0] = lockReg;
      default: begin
        for (int g = 0; g < NUM_CFG; g++) begin
          if (rdAddr == REG_AW'(CFG_BASE + g)) rdValue = cfgReg[g];
        end
      end
    endcase
  end

  assign rdData     = rdReg;
  assign globalEn   = enReg;
  assign freeze     = freezeReg;
  assign loadStrobe = pulseReg;
  assign loadAddr   = ldAddrReg[LD_AW-1:0];
  assign loadData   = ldDataReg;
  assign lockState  = lockReg;
endmodule

// File: rtl/cell_ctrl_regs.sv
module cell_ctrl_regs
  import cell_ctrl_pkg::*;
#(
  parameter int LD_AW     = 6,
  parameter int NUM_IN    = 8,
  parameter int LCL_SEL_W = 5,
  parameter int GLB_SEL_W = 7
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [3:0]        wrStrb,
  input  logic              privEn,
  input  logic              rdEn,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [31:0]       rdData,
  input  logic              dbgHalt,
  output logic              globalEn,
  output logic              freeze,
  output logic              loadStrobe,
  output logic [LD_AW-1:0]  loadAddr,
  output logic [31:0]       loadData,
  output logic              lockState
);
  wrStrobes_t strobes;

  cell_ctrl_decode u_decode (
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrKey     (wrData[31:16]),
    .wrBit0    (wrData[0]),
    .wrStrb    (wrStrb),
    .privEn    (privEn),
    .lockState (lockState),
    .strobes   (strobes)
  );

  cell_ctrl_store #(
    .LD_AW     (LD_AW),
    .NUM_IN    (NUM_IN),
    .LCL_SEL_W (LCL_SEL_W),
    .GLB_SEL_W (GLB_SEL_W)
  ) u_store (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (wrData),
    .wrStrb     (wrStrb),
    .rdEn       (rdEn),
    .rdAddr     (rdAddr),
    .dbgHalt    (dbgHalt),
    .rdData     (rdData),
    .globalEn   (globalEn),
    .freeze     (freeze),
    .loadStrobe (loadStrobe),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .lockState  (lockState)
  );
endmodule

// File: rtl/cell_ctrl_checker.sv
module cell_ctrl_checker
  import cell_ctrl_pkg::*;
#(
  parameter int LD_AW = 6
)(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [REG_AW-1:0] wrAddr,
  input logic [15:0]       wrKey,
  input logic              wrBit0,
  input logic [3:0]        wrStrb,
  input logic              privEn,
  input logic              dbgHalt,
  input logic              globalEn,
  input logic              freeze,
  input logic              loadStrobe,
  input logic [LD_AW-1:0]  loadAddr,
  input logic              lockState
);
  // R2: a load pulse only follows a load request on lane 0
  assert_pulse_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> $past(wrEn && wrAddr == IDX_CTRL && wrStrb[0] && wrBit0));

  // R3: the load address changes only on a write to its word
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == IDX_LDADDR) |=> $stable(loadAddr));

  // R5: the lock rises only after a complete keyed privileged write
  assert_lock_key_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockState) |-> $past(wrEn && wrAddr == IDX_LOCK && privEn
                               && wrStrb == 4'hF && wrKey == LOCK_KEY && wrBit0));

  // R6: the lock is sticky
  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    lockState |=> lockState);

  // R7: the enable is frozen while locked
  assert_en_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    lockState |=> $stable(globalEn));

  // R9: freeze needs a halt in the previous cycle
  assert_freeze_halt_R9: assert property (@(posedge clk) disable iff (!rstN)
    freeze |-> $past(dbgHalt));
endmodule

bind cell_ctrl_regs cell_ctrl_checker #(.LD_AW(LD_AW)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrKey      (wrData[31:16]),
  .wrBit0     (wrData[0]),
  .wrStrb     (wrStrb),
  .privEn     (privEn),
  .dbgHalt    (dbgHalt),
  .globalEn   (globalEn),
  .freeze     (freeze),
  .loadStrobe (loadStrobe),
  .loadAddr   (loadAddr),
  .lockState  (lockState)
);

// File: tb/test_cell_ctrl_regs.sv
module test_cell_ctrl_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  wrStrb = '0;
  logic        privEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  rdAddr = '0;
  logic        dbgHalt = 1'b0;
  logic [31:0] rdData;
  logic        globalEn, freeze, loadStrobe, lockState;
  logic [5:0]  loadAddr;
  logic [31:0] loadData;

  int totalCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cell_ctrl_regs i_cell_ctrl_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrStrb(wrStrb), .privEn(privEn), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .dbgHalt(dbgHalt), .globalEn(globalEn), .freeze(freeze),
    .loadStrobe(loadStrobe), .loadAddr(loadAddr), .loadData(loadData),
    .lockState(lockState)
  );

  typedef struct packed {
    logic [3:0]  addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [31:0] expect_;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 32'hFFFF_FFFF, 4'hF, 32'h0000_003F, 8'd3},  // R3 address width
    '{4'd2, 32'hDEAD_BEEF, 4'hF, 32'hDEAD_BEEF, 8'd3},  // R3 data word
    '{4'd2, 32'h1122_3344, 4'h5, 32'hDE22_BE44, 8'd4},  // R4 lanes 0 and 2
    '{4'd3, 32'hFFFF_FFFF, 4'hF, 32'h00FF_FFFF, 8'd8},  // R8 filter
    '{4'd4, 32'hFFFF_FFA5, 4'hF, 32'h0000_00A5, 8'd8},  // R8 source select
    '{4'd4, 32'h0000_FF00, 4'h2, 32'h0000_00A5, 8'd8},  // R8 reserved lane
    '{4'd5, 32'hFFFF_FFFF, 4'hF, 32'h000F_FFFF, 8'd8},  // R8 local A
    '{4'd6, 32'h1234_5678, 4'hF, 32'h0004_5678, 8'd8},  // R8 local B
    '{4'd7, 32'hFFFF_FFFF, 4'hF, 32'h0FFF_FFFF, 8'd8},  // R8 global A
    '{4'd8, 32'hABCD_EF01, 4'hC, 32'h0BCD_0000, 8'd4},  // R4 upper lanes
    '{4'd15, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000, 8'd10}, // R10 unmapped
    '{4'd1, 32'h0000_0015, 4'h0, 32'h0000_003F, 8'd4}   // R4 no lanes
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d,
                          input logic [3:0] s, input logic p);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; wrStrb = s; privEn = p;
    @(negedge clk);
    wrEn = 1'b0; wrStrb = '0; privEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", totalCount - failCount, totalCount);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    totalCount++;
    failCount++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 outputs", {globalEn, freeze, loadStrobe, lockState}, 32'h0);
    check("R1 loadData", loadData, 32'h0);
    readReg(4'd0, r); check("R1 ctrl", r, 32'h0);
    readReg(4'd3, r); check("R1 filter", r, 32'h0);
    readReg(4'd9, r); check("R1 lock", r, 32'h0);

    // table walk: write then read back
    for (int i = 0; i < NV; i++) begin
      writeReg(VECS[i].addr, VECS[i].data, VECS[i].strb, 1'b1);
      readReg(VECS[i].addr, r);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), r, VECS[i].expect_);
    end
    check("R3 loadAddr pin", 32'(loadAddr), 32'h3F);
    check("R3 loadData pin", loadData, 32'hDE22_BE44);

    // R11 enable
    writeReg(4'd0, 32'h2, 4'h1, 1'b0);
    check("R11 globalEn", 32'(globalEn), 32'h1);
    // R2 load pulse
    writeReg(4'd0, 32'h3, 4'h1, 1'b0);
    check("R2 strobe high", 32'(loadStrobe), 32'h1);
    @(negedge clk);
    check("R2 strobe low", 32'(loadStrobe), 32'h0);
    readReg(4'd0, r); check("R2 bit0 reads 0", r, 32'h2);
    writeReg(4'd0, 32'h1, 4'h2, 1'b0);
    check("R2 no pulse without lane 0", 32'(loadStrobe), 32'h0);

    // R10 read latency: value present one cycle after rdEn
    @(negedge clk); rdEn = 1'b1; rdAddr = 4'd2;
    @(negedge clk); rdEn = 1'b0;
    check("R10 latency", rdData, 32'hDE22_BE44);

    // R9 halt ignored with stop clear
    dbgHalt = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 halt ignored", 32'(freeze), 32'h0);
    writeReg(4'd0, 32'h6, 4'h1, 1'b0);
    check("R9 freeze delayed", 32'(freeze), 32'h0);
    @(negedge clk);
    check("R9 freeze set", 32'(freeze), 32'h1);
    dbgHalt = 1'b0;
    @(negedge clk);
    check("R9 freeze clear", 32'(freeze), 32'h0);

    // R5 near-miss lock writes
    writeReg(4'd9, 32'h5A5B_0001, 4'hF, 1'b1);
    check("R5 wrong key", 32'(lockState), 32'h0);
    writeReg(4'd9, 32'h5A5A_0001, 4'h7, 1'b1);
    check("R5 partial lanes", 32'(lockState), 32'h0);
    writeReg(4'd9, 32'h5A5A_0001, 4'hF, 1'b0);
    check("R5 gate closed", 32'(lockState), 32'h0);
    writeReg(4'd9, 32'h5A5A_0000, 4'hF, 1'b1);
    check("R5 bit0 clear", 32'(lockState), 32'h0);
    writeReg(4'd9, 32'h5A5A_0000, 4'hC, 1'b1);
    writeReg(4'd9, 32'h0000_0001, 4'h3, 1'b1);
    check("R5 split halves", 32'(lockState), 32'h0);
    writeReg(4'd9, 32'h5A5A_0001, 4'hF, 1'b1);
    check("R5 lock set", 32'(lockState), 32'h1);
    readReg(4'd9, r); check("R10 key reads 0", r, 32'h1);

    // R7 protection
    writeReg(4'd3, 32'h0, 4'hF, 1'b1);
    readReg(4'd3, r); check("R7 filter held", r, 32'h00FF_FFFF);
    writeReg(4'd5, 32'h0, 4'hF, 1'b1);
    readReg(4'd5, r); check("R7 local A held", r, 32'h000F_FFFF);
    writeReg(4'd8, 32'h0, 4'hF, 1'b1);
    readReg(4'd8, r); check("R7 global B held", r, 32'h0BCD_0000);
    writeReg(4'd0, 32'h0, 4'h1, 1'b1);
    check("R7 enable held", 32'(globalEn), 32'h1);
    readReg(4'd0, r); check("R7 stop cleared", r, 32'h2);
    writeReg(4'd0, 32'h1, 4'h1, 1'b0);
    check("R7 load pulse while locked", 32'(loadStrobe), 32'h1);
    writeReg(4'd2, 32'hCAFE_F00D, 4'hF, 1'b0);
    check("R7 data writable", loadData, 32'hCAFE_F00D);

    // R6 sticky
    writeReg(4'd9, 32'h5A5A_0000, 4'hF, 1'b1);
    check("R6 sticky", 32'(lockState), 32'h1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R6 reset clears lock", 32'(lockState), 32'h0);
    check("R1 enable after reset", 32'(globalEn), 32'h0);
    readReg(4'd3, r); check("R1 filter after reset", r, 32'h0);

    finish();
  end
endmodule